// File: doc/BRIEF.md
# PCIe Address Translation Viewport Unit

This block translates request addresses through a bank of programmable windows. Each direction, inbound and outbound, has its own set of regions. Each region holds a base address, a 32-bit upper limit, a target address, a type and an enable. A request whose address falls inside an enabled region of its direction comes out one cycle later in one of two forms. A memory hit gives a rebased target address. A configuration hit is split into a bus number, a device/function number and a register offset inside configuration space. A request that falls in no region is reported as a miss.

Software reaches the regions through one indirect window. A select register names one region and its direction, and a fixed group of offsets then accesses that region's fields. Writes to those fields only stage new values. The lookup logic uses the staged values only after the second control word is written, so a region can be fully reprogrammed while it is still in use. For configuration hits, the unit also decides what happens when the addressed device is absent. A read returns all ones, and a write is not passed on.

Top module: `atu_viewport_unit`

## Requirements
- R1: After reset every region reads back base 0, target 0, limit 0xFFFFFFFF and control 1 of 0. Inbound region 0 is live and enabled, with control 2 reading 0x80000000. Every other region is disabled, with control 2 reading 0.
- R2: The select register sits at offset 0x900 and reads back the last value written. Bits 3:0 give the region index, and bit 31 chooses the inbound set (1) or the outbound set (0).
- R3: The field registers act on the selected region and read back its staged values: control 1 at 0x904, control 2 at 0x908, base low/high at 0x90C/0x910, limit at 0x914, target low/high at 0x918/0x91C. A low-half write changes only bits 31:0, and a high-half write changes only bits 63:32. The read data does not change while no register write occurs and the offset is held.
- R4: Staged base, limit, target and control 1 values have no effect on lookups until control 2 of that region is written. That write copies them into the live region.
- R5: Control 2 bit 31 is the region enable. A disabled region never produces a hit.
- R6: A region matches when base <= address <= limit, with the limit zero-extended to 64 bits. A miss returns hit 0, region 0, type 0 and all translated fields 0.
- R7: A memory hit returns target + (address - base).
- R8: Control 1 equal to 0 makes the region a memory region, and any other value makes it a configuration region. A configuration hit returns a memory address of 0, bus = target[31:24], device/function = target[23:16], and offset = (address - base) modulo the configuration space size (4096 bytes by default). Rewriting the type switches the region between the two mappings.
- R9: When several enabled regions match, the lowest-numbered one is reported.
- R10: On a configuration hit with the device absent, the read data output is all ones and the write-forward output stays low. With the device present, the device's read data is passed through and a write is forwarded.
- R11: A response is valid exactly one cycle after each request cycle and at no other time.
- R12: A lookup consults only the regions of its own direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Lookup request strobe |
| req_inbound | input | 1 | 1 selects the inbound regions, 0 the outbound regions |
| req_write | input | 1 | Request is a write |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | An enabled region matched |
| rsp_is_cfg | output | 1 | Matching region is of configuration type |
| rsp_region | output | IDX_W | Index of the matching region |
| rsp_mem_addr | output | 64 | Translated memory address |
| rsp_cfg_bus | output | 8 | Configuration bus number |
| rsp_cfg_devfn | output | 8 | Configuration device/function |
| rsp_cfg_offset | output | CFG_OFF_W | Configuration register offset |
| dev_present | input | 1 | Addressed configuration device exists |
| dev_rdata | input | 32 | Read data from the addressed device |
| cfg_wr_fwd | output | 1 | Forward the configuration write to the device |
| cfg_rd_data | output | 32 | Configuration read data returned to the requester |

## Verification
The checker watches four properties on every cycle. Responses follow requests one-for-one, one cycle later. Misses and configuration hits never carry a memory address. An absent device never receives a forwarded write and always reads as all ones. The read window stays steady when no write occurs. Only the bench scenarios can show the stateful behaviour: staged values having no effect until the commit write, the type switch, the half-word merges, overlap priority, separation between directions, and the exact translated addresses. Each of these depends on a programming sequence that a single-cycle property cannot see.

// File: rtl/atu_pkg.sv
package atu_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned ATU_AW = 64;
   localparam int unsigned ATU_LW = 32;

   // indirect window offsets (software-visible layout)
   localparam logic [11:0] OFS_SEL  = 12'h900;
   localparam logic [11:0] OFS_CTL1 = 12'h904;
   localparam logic [11:0] OFS_CTL2 = 12'h908;
   localparam logic [11:0] OFS_BLO  = 12'h90C;
   localparam logic [11:0] OFS_BHI  = 12'h910;
   localparam logic [11:0] OFS_LIM  = 12'h914;
   localparam logic [11:0] OFS_TLO  = 12'h918;
   localparam logic [11:0] OFS_THI  = 12'h91C;

   localparam int unsigned DIR_BIT = 31;
   localparam int unsigned EN_BIT  = 31;

   typedef struct packed {
      logic [ATU_AW-1:0] base;
      logic [ATU_LW-1:0] limit;
      logic [ATU_AW-1:0] target;
      logic [31:0]       ctl1;
      logic [31:0]       ctl2;
   } atu_stage_t;

   typedef struct packed {
      logic              en;
      logic              is_cfg;
      logic [ATU_AW-1:0] base;
      logic [ATU_LW-1:0] limit;
      logic [ATU_AW-1:0] target;
   } atu_live_t;

   localparam atu_stage_t STAGE_RST = '{base: '0, limit: '1, target: '0, ctl1: '0, ctl2: '0};
   localparam atu_live_t  LIVE_RST  = '{en: 1'b0, is_cfg: 1'b0, base: '0, limit: '1, target: '0};
endpackage

// File: rtl/atu_window_regs.sv
module atu_window_regs
   import atu_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 16,
   localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [11:0]                        addr,
   input  logic [31:0]                        wdata,
   output logic [31:0]                        rdata,
   output atu_live_t [NUM_REGIONS-1:0]        live_ob,
   output atu_live_t [NUM_REGIONS-1:0]        live_ib
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [31:0]                             sel_q;
   atu_stage_t [1:0][NUM_REGIONS-1:0]       stg_q;
   atu_live_t  [1:0][NUM_REGIONS-1:0]       live_q;

   logic             sel_dir;
   logic [IDX_W-1:0] sel_idx;
   atu_stage_t       cur;

   assign sel_dir = sel_q[DIR_BIT];
   assign sel_idx = sel_q[IDX_W-1:0];
   assign cur     = stg_q[sel_dir][sel_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         for (int d = 0; d < 2; d++) begin
            for (int r = 0; r < int'(NUM_REGIONS); r++) begin
               stg_q[d][r]  <= STAGE_RST;
               live_q[d][r] <= LIVE_RST;
            end
         end
         // inbound region 0 passes traffic out of reset
         stg_q[1][0].ctl2 <= 32'h8000_0000;
         live_q[1][0].en  <= 1'b1;
      end else if (wr_en) begin
         case (addr)
            OFS_SEL:  sel_q <= wdata;
            OFS_CTL1: stg_q[sel_dir][sel_idx].ctl1 <= wdata;
            OFS_CTL2: begin
               stg_q[sel_dir][sel_idx].ctl2 <= wdata;
               live_q[sel_dir][sel_idx] <= '{en: wdata[EN_BIT], is_cfg: (cur.ctl1 != 32'h0),
                                            base: cur.base, limit: cur.limit, target: cur.target};
            end
            OFS_BLO:  stg_q[sel_dir][sel_idx].base[31:0]    <= wdata;
            OFS_BHI:  stg_q[sel_dir][sel_idx].base[63:32]   <= wdata;
            OFS_LIM:  stg_q[sel_dir][sel_idx].limit         <= wdata;
            OFS_TLO:  stg_q[sel_dir][sel_idx].target[31:0]  <= wdata;
            OFS_THI:  stg_q[sel_dir][sel_idx].target[63:32] <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         OFS_SEL:  rdata = sel_q;
         OFS_CTL1: rdata = cur.ctl1;
         OFS_CTL2: rdata = cur.ctl2;
         OFS_BLO:  rdata = cur.base[31:0];
         OFS_BHI:  rdata = cur.base[63:32];
         OFS_LIM:  rdata = cur.limit;
         OFS_TLO:  rdata = cur.target[31:0];
         OFS_THI:  rdata = cur.target[63:32];
         default:  rdata = 32'h0;
      endcase
   end

   assign live_ob = live_q[0];
   assign live_ib = live_q[1];
endmodule

// File: rtl/atu_match.sv
module atu_match
   import atu_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 16,
   localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
   input  atu_live_t [NUM_REGIONS-1:0] regions,
   input  logic [ATU_AW-1:0]           addr,
   output logic                        hit,
   output logic [IDX_W-1:0]            idx
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [NUM_REGIONS-1:0] hv;

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
      assign hv[r] = regions[r].en
                   && (addr >= regions[r].base)
                   && (addr <= {{(ATU_AW-ATU_LW){1'b0}}, regions[r].limit});
   end

   // lowest index wins: scan from the top so the smallest match is left last
   always_comb begin
      idx = '0;
      for (int r = int'(NUM_REGIONS) - 1; r >= 0; r--) begin
         if (hv[r]) idx = IDX_W'(r);
      end
   end

   assign hit = |hv;
endmodule

// File: rtl/atu_xlate.sv
module atu_xlate
   import atu_pkg::*;
#(
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned CFG_OFF_W = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_write,
   input  logic                 in_hit,
   input  logic [IDX_W-1:0]     in_idx,
   input  logic                 in_is_cfg,
   input  logic [ATU_AW-1:0]    in_base,
   input  logic [ATU_AW-1:0]    in_target,
   input  logic [ATU_AW-1:0]    in_addr,
   output logic                 rsp_valid,
   output logic                 rsp_write,
   output logic                 rsp_hit,
   output logic                 rsp_is_cfg,
   output logic [IDX_W-1:0]     rsp_region,
   output logic [ATU_AW-1:0]    rsp_mem_addr,
   output logic [7:0]           rsp_cfg_bus,
   output logic [7:0]           rsp_cfg_devfn,
   output logic [CFG_OFF_W-1:0] rsp_cfg_offset
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [ATU_AW-1:0] offs;
   logic [ATU_AW-1:0] mem_nxt;
   logic              mem_hit;
   logic              cfg_hit;

   assign offs    = in_addr - in_base;
   assign mem_nxt = in_target + offs;
   assign cfg_hit = in_hit && in_is_cfg;
   assign mem_hit = in_hit && !in_is_cfg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_write      <= 1'b0;
         rsp_hit        <= 1'b0;
         rsp_is_cfg     <= 1'b0;
         rsp_region     <= '0;
         rsp_mem_addr   <= '0;
         rsp_cfg_bus    <= '0;
         rsp_cfg_devfn  <= '0;
         rsp_cfg_offset <= '0;
      end else begin
         rsp_valid <= in_valid;
         if (in_valid) begin
            rsp_write      <= in_write;
            rsp_hit        <= in_hit;
            rsp_is_cfg     <= cfg_hit;
            rsp_region     <= in_hit ? in_idx : '0;
            rsp_mem_addr   <= mem_hit ? mem_nxt : '0;
            rsp_cfg_bus    <= cfg_hit ? in_target[31:24] : 8'h0;
            rsp_cfg_devfn  <= cfg_hit ? in_target[23:16] : 8'h0;
            rsp_cfg_offset <= cfg_hit ? offs[CFG_OFF_W-1:0] : '0;
         end
      end
   end
endmodule

// File: rtl/atu_viewport_unit.sv
module atu_viewport_unit
   import atu_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 16,
   parameter int unsigned CFG_BYTES   = 4096,
   localparam int unsigned IDX_W      = $clog2(NUM_REGIONS),
   localparam int unsigned CFG_OFF_W  = $clog2(CFG_BYTES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr_en,
   input  logic [11:0]          reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 req_valid,
   input  logic                 req_inbound,
   input  logic                 req_write,
   input  logic [63:0]          req_addr,
   output logic                 rsp_valid,
   output logic                 rsp_hit,
   output logic                 rsp_is_cfg,
   output logic [IDX_W-1:0]     rsp_region,
   output logic [63:0]          rsp_mem_addr,
   output logic [7:0]           rsp_cfg_bus,
   output logic [7:0]           rsp_cfg_devfn,
   output logic [CFG_OFF_W-1:0] rsp_cfg_offset,
   input  logic                 dev_present,
   input  logic [31:0]          dev_rdata,
   output logic                 cfg_wr_fwd,
   output logic [31:0]          cfg_rd_data
);
   timeunit 1ns;
   timeprecision 1ps;

   if (NUM_REGIONS < 2 || NUM_REGIONS > 16 || (NUM_REGIONS & (NUM_REGIONS - 1)) != 0) begin : g_bad_regions
      $error("NUM_REGIONS must be a power of two from 2 to 16");
   end
   if (CFG_BYTES < 256 || CFG_BYTES > 4096 || (CFG_BYTES & (CFG_BYTES - 1)) != 0) begin : g_bad_cfg
      $error("CFG_BYTES must be a power of two from 256 to 4096");
   end

   atu_live_t [NUM_REGIONS-1:0] live_ob;
   atu_live_t [NUM_REGIONS-1:0] live_ib;
   atu_live_t [NUM_REGIONS-1:0] live_sel;
   atu_live_t                   win;
   logic                        m_hit;
   logic [IDX_W-1:0]            m_idx;
   logic                        rsp_write;

   atu_window_regs #(.NUM_REGIONS(NUM_REGIONS)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .live_ob (live_ob),
      .live_ib (live_ib)
   );

   assign live_sel = req_inbound ? live_ib : live_ob;

   atu_match #(.NUM_REGIONS(NUM_REGIONS)) match_i (
      .regions (live_sel),
      .addr    (req_addr),
      .hit     (m_hit),
      .idx     (m_idx)
   );

   assign win = live_sel[m_idx];

   atu_xlate #(.IDX_W(IDX_W), .CFG_OFF_W(CFG_OFF_W)) xlate_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (req_valid),
      .in_write       (req_write),
      .in_hit         (m_hit),
      .in_idx         (m_idx),
      .in_is_cfg      (win.is_cfg),
      .in_base        (win.base),
      .in_target      (win.target),
      .in_addr        (req_addr),
      .rsp_valid      (rsp_valid),
      .rsp_write      (rsp_write),
      .rsp_hit        (rsp_hit),
      .rsp_is_cfg     (rsp_is_cfg),
      .rsp_region     (rsp_region),
      .rsp_mem_addr   (rsp_mem_addr),
      .rsp_cfg_bus    (rsp_cfg_bus),
      .rsp_cfg_devfn  (rsp_cfg_devfn),
      .rsp_cfg_offset (rsp_cfg_offset)
   );

   assign cfg_wr_fwd  = rsp_valid && rsp_hit && rsp_is_cfg && rsp_write && dev_present;
   assign cfg_rd_data = (rsp_hit && rsp_is_cfg && dev_present) ? dev_rdata : 32'hFFFF_FFFF;
endmodule

// File: rtl/atu_viewport_sva.sv
module atu_viewport_sva #(
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned CFG_OFF_W = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_wr_en,
   input logic [11:0]          reg_addr,
   input logic [31:0]          reg_rdata,
   input logic                 req_valid,
   input logic                 rsp_valid,
   input logic                 rsp_hit,
   input logic                 rsp_is_cfg,
   input logic [IDX_W-1:0]     rsp_region,
   input logic [63:0]          rsp_mem_addr,
   input logic [CFG_OFF_W-1:0] rsp_cfg_offset,
   input logic                 dev_present,
   input logic                 cfg_wr_fwd,
   input logic [31:0]          cfg_rd_data
);
   timeunit 1ns;
   timeprecision 1ps;

   a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r6_miss_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_mem_addr == 64'h0 && !rsp_is_cfg
                                   && rsp_region == '0 && rsp_cfg_offset == '0));

   a_r8_cfg_has_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_is_cfg) |-> (rsp_mem_addr == 64'h0));

   a_r10_absent_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_present |-> !cfg_wr_fwd);

   a_r10_absent_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && rsp_is_cfg && !dev_present) |-> (cfg_rd_data == 32'hFFFF_FFFF));

   a_r3_readback_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!reg_wr_en) && $stable(reg_addr)) |-> $stable(reg_rdata));
endmodule

bind atu_viewport_unit atu_viewport_sva #(.IDX_W(IDX_W), .CFG_OFF_W(CFG_OFF_W)) sva_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .reg_wr_en      (reg_wr_en),
   .reg_addr       (reg_addr),
   .reg_rdata      (reg_rdata),
   .req_valid      (req_valid),
   .rsp_valid      (rsp_valid),
   .rsp_hit        (rsp_hit),
   .rsp_is_cfg     (rsp_is_cfg),
   .rsp_region     (rsp_region),
   .rsp_mem_addr   (rsp_mem_addr),
   .rsp_cfg_offset (rsp_cfg_offset),
   .dev_present    (dev_present),
   .cfg_wr_fwd     (cfg_wr_fwd),
   .cfg_rd_data    (cfg_rd_data)
);

// File: tb/atu_viewport_unit_tb_top.sv
module atu_viewport_unit_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [31:0] DEV_DATA = 32'hC0DE_0042;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [11:0] reg_addr = 12'h0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic        req_inbound = 1'b0;
   logic        req_write = 1'b0;
   logic [63:0] req_addr = 64'h0;
   logic        rsp_valid, rsp_hit, rsp_is_cfg;
   logic [3:0]  rsp_region;
   logic [63:0] rsp_mem_addr;
   logic [7:0]  rsp_cfg_bus, rsp_cfg_devfn;
   logic [11:0] rsp_cfg_offset;
   logic        dev_present = 1'b0;
   logic [31:0] dev_rdata = DEV_DATA;
   logic        cfg_wr_fwd;
   logic [31:0] cfg_rd_data;

   int n_tests = 0;
   int n_fail  = 0;

   typedef struct packed {
      logic        hit;
      logic        cfg;
      logic [3:0]  idx;
      logic [63:0] mem;
      logic [7:0]  bus;
      logic [7:0]  devfn;
      logic [11:0] off;
      logic        fwd;
      logic [31:0] rd;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   atu_viewport_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_inbound(req_inbound), .req_write(req_write), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_is_cfg(rsp_is_cfg), .rsp_region(rsp_region),
      .rsp_mem_addr(rsp_mem_addr), .rsp_cfg_bus(rsp_cfg_bus), .rsp_cfg_devfn(rsp_cfg_devfn),
      .rsp_cfg_offset(rsp_cfg_offset), .dev_present(dev_present), .dev_rdata(dev_rdata),
      .cfg_wr_fwd(cfg_wr_fwd), .cfg_rd_data(cfg_rd_data)
   );

   task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(tag, $sformatf("reg 0x%0h", a), {32'h0, reg_rdata}, {32'h0, exp});
   endtask

   // driver: pushes the expected result, then issues a one-cycle request
   task automatic lookup(input string tag, input bit inb, input logic [63:0] a, input bit wr,
                         input bit pres, input bit eh, input bit ec, input int ei,
                         input logic [63:0] em, input logic [7:0] eb, input logic [7:0] ed,
                         input logic [11:0] eo);
      exp_t e;
      e.hit = eh; e.cfg = ec; e.idx = ei[3:0]; e.mem = em;
      e.bus = eb; e.devfn = ed; e.off = eo;
      e.fwd = eh && ec && wr && pres;                        // R10
      e.rd  = (eh && ec && pres) ? DEV_DATA : 32'hFFFF_FFFF; // R10
      @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      req_valid = 1'b1; req_inbound = inb; req_addr = a; req_write = wr; dev_present = pres;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: compares each response against the head of the queue (R11)
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
               check("R11", "unexpected response", 64'h1, 64'h0);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, "hit",    {63'h0, rsp_hit},        {63'h0, e.hit});
               check(t, "is_cfg", {63'h0, rsp_is_cfg},     {63'h0, e.cfg});
               check(t, "region", {60'h0, rsp_region},     {60'h0, e.idx});
               check(t, "mem",    rsp_mem_addr,            e.mem);
               check(t, "bus",    {56'h0, rsp_cfg_bus},    {56'h0, e.bus});
               check(t, "devfn",  {56'h0, rsp_cfg_devfn},  {56'h0, e.devfn});
               check(t, "offset", {52'h0, rsp_cfg_offset}, {52'h0, e.off});
               check(t, "fwd",    {63'h0, cfg_wr_fwd},     {63'h0, e.fwd});
               check(t, "rd",     {32'h0, cfg_rd_data},    {32'h0, e.rd});
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R11 watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset contents, outbound region 0 selected
      check("R11", "rsp_valid idle", {63'h0, rsp_valid}, 64'h0);
      reg_rd("R1", 12'h900, 32'h0);
      reg_rd("R1", 12'h90C, 32'h0);
      reg_rd("R1", 12'h914, 32'hFFFF_FFFF);
      reg_rd("R1", 12'h918, 32'h0);
      reg_rd("R1", 12'h904, 32'h0);
      reg_rd("R1", 12'h908, 32'h0);
      reg_wr(12'h900, 32'h8000_0000);
      reg_rd("R1", 12'h908, 32'h8000_0000);
      lookup("R1", 1'b0, 64'h1000, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0);
      lookup("R1", 1'b1, 64'h1234, 1'b0, 1'b0, 1, 0, 0, 64'h1234, 0, 0, 0);
      lookup("R6", 1'b1, 64'hFFFF_FFFF, 1'b0, 1'b0, 1, 0, 0, 64'hFFFF_FFFF, 0, 0, 0);
      lookup("R6", 1'b1, 64'h1_0000_0000, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0);

      // R2 select register readback
      reg_wr(12'h900, 32'h8000_0005);
      reg_rd("R2", 12'h900, 32'h8000_0005);

      // R3 outbound region 2 staging and half-word writes
      reg_wr(12'h900, 32'h0000_0002);
      reg_wr(12'h90C, 32'h4000_0000);
      reg_wr(12'h910, 32'h0);
      reg_wr(12'h914, 32'h4FFF_FFFF);
      reg_wr(12'h918, 32'h8000_0000);
      reg_wr(12'h91C, 32'h0000_0001);
      reg_rd("R3", 12'h918, 32'h8000_0000);
      reg_rd("R3", 12'h91C, 32'h0000_0001);
      reg_rd("R3", 12'h90C, 32'h4000_0000);
      reg_rd("R3", 12'h914, 32'h4FFF_FFFF);
      // R4 nothing live before the commit write
      lookup("R4", 1'b0, 64'h4000_0010, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0);
      reg_wr(12'h904, 32'h0);
      reg_wr(12'h908, 32'h8000_0000);
      lookup("R7", 1'b0, 64'h4000_0010, 1'b0, 1'b0, 1, 0, 2, 64'h1_8000_0010, 0, 0, 0);
      lookup("R6", 1'b0, 64'h3FFF_FFFF, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0);
      lookup("R6", 1'b0, 64'h4FFF_FFFF, 1'b0, 1'b0, 1, 0, 2, 64'h1_8FFF_FFFF, 0, 0, 0);

      // R4 restage base: old mapping stays until control 2 is written
      reg_wr(12'h90C, 32'h4800_0000);
      lookup("R4", 1'b0, 64'h4000_0010, 1'b0, 1'b0, 1, 0, 2, 64'h1_8000_0010, 0, 0, 0);
      reg_wr(12'h908, 32'h8000_0000);
      lookup("R4", 1'b0, 64'h4000_0010, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0);
      lookup("R7", 1'b0, 64'h4800_0000, 1'b0, 1'b0, 1, 0, 2, 64'h1_8000_0000, 0, 0, 0);

      // R9 overlapping outbound region 1 wins over region 2
      reg_wr(12'h900, 32'h0000_0001);
      reg_wr(12'h90C, 32'h4800_0000);
      reg_wr(12'h914, 32'h48FF_FFFF);
      reg_wr(12'h918, 32'h2000_0000);
      reg_wr(12'h908, 32'h8000_0000);
      lookup("R9", 1'b0, 64'h4800_0100, 1'b0, 1'b0, 1, 0, 1, 64'h2000_0100, 0, 0, 0);

      // R8 configuration region 3: bus 0x03, devfn 0x12
      reg_wr(12'h900, 32'h0000_0003);
      reg_wr(12'h90C, 32'h6000_0000);
      reg_wr(12'h914, 32'h600F_FFFF);
      reg_wr(12'h918, 32'h0312_0000);
      reg_wr(12'h904, 32'h0000_0004);
      reg_wr(12'h908, 32'h8000_0000);
      lookup("R8", 1'b0, 64'h6000_1ABC, 1'b0, 1'b0, 1, 1, 3, 0, 8'h03, 8'h12, 12'hABC);
      lookup("R10", 1'b0, 64'h6000_0040, 1'b1, 1'b1, 1, 1, 3, 0, 8'h03, 8'h12, 12'h040);
      lookup("R10", 1'b0, 64'h6000_0044, 1'b1, 1'b0, 1, 1, 3, 0, 8'h03, 8'h12, 12'h044);
      lookup("R10", 1'b0, 64'h6000_0048, 1'b0, 1'b1, 1, 1, 3, 0, 8'h03, 8'h12, 12'h048);

      // R8 switch region 3 back to memory type
      reg_wr(12'h904, 32'h0);
      reg_wr(12'h908, 32'h8000_0000);
      lookup("R8", 1'b0, 64'h6000_0010, 1'b0, 1'b1, 1, 0, 3, 64'h0312_0010, 0, 0, 0);

      // R5 disabling region 1 exposes region 2 again
      reg_wr(12'h900, 32'h0000_0001);
      reg_wr(12'h908, 32'h0);
      lookup("R5", 1'b0, 64'h4800_0100, 1'b0, 1'b0, 1, 0, 2, 64'h1_8000_0100, 0, 0, 0);

      // R12 inbound region 5, then disable inbound region 0
      reg_wr(12'h900, 32'h8000_0005);
      reg_wr(12'h90C, 32'h9000_0000);
      reg_wr(12'h914, 32'h9000_FFFF);
      reg_wr(12'h918, 32'h0010_0000);
      reg_wr(12'h908, 32'h8000_0000);
      lookup("R9", 1'b1, 64'h9000_0004, 1'b0, 1'b0, 1, 0, 0, 64'h9000_0004, 0, 0, 0);
      reg_wr(12'h900, 32'h8000_0000);
      reg_wr(12'h908, 32'h0);
      lookup("R12", 1'b1, 64'h9000_0004, 1'b0, 1'b0, 1, 0, 5, 64'h0010_0004, 0, 0, 0);
      lookup("R12", 1'b0, 64'h9000_0004, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0);
      lookup("R5", 1'b1, 64'h1234, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0);

      repeat (4) @(negedge clk);
      check("R11", "pending responses", 64'(exp_q.size()), 64'h0);
      check("R11", "rsp_valid idle", {63'h0, rsp_valid}, 64'h0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule